// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block is a 16-bit up-counting timer with two compare channels. The counter advances once per prescaled tick, and the tick is derived from the system clock divided by 2, 4 or 8. Each channel holds a 16-bit compare value. When the counter equals that value on a tick, the channel raises its status flag. If its output is enabled, it also loads a programmed level into its output pin latch. A shared interrupt line is raised when a flag is set, interrupts are enabled, and the external mask input is low.

Software reaches everything through a small byte-wide register bus. Each compare value is split into a high byte and a low byte at separate addresses. Writing a high byte holds off compare events on that channel until the low byte is written. A flag is cleared by first reading the status register while the flag is set, and then accessing that channel's low compare byte.

Top module: `ocmp_timer`

## Requirements
- R1: While reset is asserted, the counter reads 0000h and both compare registers read 8000h. Status, both control registers, `irq`, `ocmp_out` and `ocmp_oe` are all zero.
- R2: Control register B bits [1:0] select the prescaler: 00 divides by 2, 01 by 4, and 10 or 11 by 8. The counter advances exactly once per that many clocks.
- R3: The counter increments by one on each tick and wraps from FFFFh to 0000h.
- R4: Register map, with reads combinational on `bus_addr`: 0 is control A, 1 is control B, 2 is status, 3 and 4 are counter high and low, 5 and 6 are channel 1 compare high and low, 7 and 8 are channel 2 compare high and low.
- R5: A compare register changes only when software writes it. It keeps its value across matches.
- R6: A channel's status flag (status bit 0 for channel 1, bit 1 for channel 2) is set at the clock edge where a tick occurs while the counter equals its compare value. Right after that edge the counter reads compare+1.
- R7: Control B bit 2 (channel 1) and bit 3 (channel 2) enable the outputs and appear on `ocmp_oe`. On a match with the output enabled, the pin latch takes the level in control A bit 1 (channel 1) or bit 2 (channel 2).
- R8: On a match with the output disabled, the pin latch keeps its previous value.
- R9: `irq` is high exactly when control A bit 0 is set, at least one flag is set, and `irq_mask` is low.
- R10: Writing a compare high byte blocks compare events on that channel until its low byte is written.
- R11: A flag clears only after a status read made while the flag is set, followed by a read or write of that channel's compare low byte. A low-byte access without that status read, or a status read alone, leaves the flag set.
- R12: The channels are independent. A match on channel 2 does not set flag 1 or change pin 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (for read side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| irq_mask | input | 1 | Global interrupt mask, high blocks `irq` |
| irq | output | 1 | Timer interrupt |
| ocmp_out | output | 2 | Output pin latches, bit 0 is channel 1 |
| ocmp_oe | output | 2 | Output-enable state per channel |

## Verification
The prescaler is exercised in all four settings, and the spacing between counter steps is measured; this separates the three divide ratios and shows that the spare code maps to divide-by-8. Compare targets are placed a few ticks ahead of the live counter with each combination of output enable and level. This shows whether a match loads the level, whether an enable that is off protects the latch, and whether a match on one channel leaks into the other. A fully written compare value whose low byte is still pending sits in the counter's path. A flag then appearing would reveal the missing hold-off. Separately, the counter is run through its full wrap to hit a compare value of zero.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int A_CTRL_A   = 0;
  localparam int A_CTRL_B   = 1;
  localparam int A_STAT     = 2;
  localparam int A_CNT_H    = 3;
  localparam int A_CNT_L    = 4;
  localparam int A_CMP_BASE = 5;

  typedef enum logic [1:0] {
    DIV2  = 2'b00,
    DIV4  = 2'b01,
    DIV8  = 2'b10,
    DIV8X = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/ocmp_prescaler.sv
module ocmp_prescaler
  import ocmp_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [DIV_W-1:0] div_q, div_d, lim;

  always_comb begin
    unique case (clk_sel_e'(sel))
      DIV2:    lim = DIV_W'(1);
      DIV4:    lim = DIV_W'(3);
      default: lim = DIV_W'(7);
    endcase
    // >= so a ratio change mid-count cannot overrun
    tick  = (div_q >= lim);
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic               acc_lo,
  input  logic               stat_rd,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic               oe,
  input  logic               lvl,
  output logic [CNT_W-1:0]   cmp,
  output logic               flag,
  output logic               pin,
  output logic               hold
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic hold_q, hold_d, arm_q, arm_d, flag_q, flag_d, pin_q, pin_d;
  logic match;

  always_comb begin
    match = tick & ~hold_q & (cnt == cmp_q);

    cmp_d = cmp_q;
    if (wr_hi) cmp_d[CNT_W-1:HALF] = wdata;
    if (wr_lo) cmp_d[HALF-1:0]     = wdata;

    hold_d = wr_hi ? 1'b1 : (wr_lo ? 1'b0 : hold_q);

    // clear sequence: status read seen with flag up, then low-byte access
    arm_d = acc_lo ? 1'b0 : ((stat_rd & flag_q) ? 1'b1 : arm_q);

    // a new match wins over a clear in the same cycle
    flag_d = match ? 1'b1 : ((acc_lo & arm_q) ? 1'b0 : flag_q);

    pin_d = (match & oe) ? lvl : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= RST_VAL;
      hold_q <= 1'b0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      hold_q <= hold_d;
      arm_q  <= arm_d;
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  assign cmp  = cmp_q;
  assign flag = flag_q;
  assign pin  = pin_q;
  assign hold = hold_q;
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  input  logic               irq_mask,
  output logic               irq,
  output logic [NCH-1:0]     ocmp_out,
  output logic [NCH-1:0]     ocmp_oe
);
  localparam int HALF  = CNT_W / 2;
  localparam int CA_W  = 1 + NCH;
  localparam int CB_W  = 2 + NCH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic [CA_W-1:0] ctrl_a_q, ctrl_a_d;
  logic [CB_W-1:0] ctrl_b_q, ctrl_b_d;
  logic            wr_a, wr_b, stat_rd;
  logic            tick;
  logic [CNT_W-1:0] cnt;
  logic [NCH-1:0][CNT_W-1:0] cmp_v;
  logic [NCH-1:0]  flags, hold_v, oe_v, lvl_v, wr_hi, wr_lo, acc_lo;

  assign wr_a    = bus_sel & bus_wr & (bus_addr == ADDR_W'(A_CTRL_A));
  assign wr_b    = bus_sel & bus_wr & (bus_addr == ADDR_W'(A_CTRL_B));
  assign stat_rd = bus_sel & bus_rd & (bus_addr == ADDR_W'(A_STAT));

  always_comb begin
    ctrl_a_d = wr_a ? bus_wdata[CA_W-1:0] : ctrl_a_q;
    ctrl_b_d = wr_b ? bus_wdata[CB_W-1:0] : ctrl_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
    end else begin
      ctrl_a_q <= ctrl_a_d;
      ctrl_b_q <= ctrl_b_d;
    end
  end

  ocmp_prescaler #(.DIV_W(3)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_b_q[1:0]), .tick(tick)
  );

  ocmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int HI_A = A_CMP_BASE + 2 * i;
    localparam int LO_A = HI_A + 1;

    assign wr_hi[i]  = bus_sel & bus_wr & (bus_addr == ADDR_W'(HI_A));
    assign wr_lo[i]  = bus_sel & bus_wr & (bus_addr == ADDR_W'(LO_A));
    assign acc_lo[i] = bus_sel & (bus_wr | bus_rd) & (bus_addr == ADDR_W'(LO_A));
    assign oe_v[i]   = ctrl_b_q[2+i];
    assign lvl_v[i]  = ctrl_a_q[1+i];

    ocmp_channel #(
      .CNT_W  (CNT_W),
      .RST_VAL(CNT_W'(1) << (CNT_W - 1))
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt    (cnt),
      .wr_hi  (wr_hi[i]),
      .wr_lo  (wr_lo[i]),
      .acc_lo (acc_lo[i]),
      .stat_rd(stat_rd),
      .wdata  (bus_wdata),
      .oe     (oe_v[i]),
      .lvl    (lvl_v[i]),
      .cmp    (cmp_v[i]),
      .flag   (flags[i]),
      .pin    (ocmp_out[i]),
      .hold   (hold_v[i])
    );
  end

  assign ocmp_oe = oe_v;
  assign irq     = ctrl_a_q[0] & (|flags) & ~irq_mask;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL_A)) bus_rdata = HALF'(ctrl_a_q);
    if (bus_addr == ADDR_W'(A_CTRL_B)) bus_rdata = HALF'(ctrl_b_q);
    if (bus_addr == ADDR_W'(A_STAT))   bus_rdata = HALF'(flags);
    if (bus_addr == ADDR_W'(A_CNT_H))  bus_rdata = cnt[CNT_W-1:HALF];
    if (bus_addr == ADDR_W'(A_CNT_L))  bus_rdata = cnt[HALF-1:0];
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(A_CMP_BASE + 2 * i))     bus_rdata = cmp_v[i][CNT_W-1:HALF];
      if (bus_addr == ADDR_W'(A_CMP_BASE + 2 * i + 1)) bus_rdata = cmp_v[i][HALF-1:0];
    end
  end
endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [CNT_W-1:0]          cnt,
  input logic [NCH-1:0][CNT_W-1:0] cmp_v,
  input logic [NCH-1:0]            flags,
  input logic [NCH-1:0]            hold_v,
  input logic [NCH-1:0]            oe_v,
  input logic [NCH-1:0]            pins,
  input logic [NCH-1:0]            wr_hi,
  input logic [NCH-1:0]            wr_lo,
  input logic                      irq,
  input logic                      irq_mask
);
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '1) |=> (cnt == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(tick && cnt == cmp_v[i]));

    a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v[i] |=> !$rose(flags[i]));

    a_r8_pin_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_v[i] |=> $stable(pins[i]));

    a_r5_cmp_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hi[i] || wr_lo[i]) |=> $stable(cmp_v[i]));
  end
endmodule

bind ocmp_timer ocmp_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .cnt     (cnt),
  .cmp_v   (cmp_v),
  .flags   (flags),
  .hold_v  (hold_v),
  .oe_v    (oe_v),
  .pins    (ocmp_out),
  .wr_hi   (wr_hi),
  .wr_lo   (wr_lo),
  .irq     (irq),
  .irq_mask(irq_mask)
);

// File: tb/ocmp_timer_test.sv
`timescale 1ns/1ps
module ocmp_timer_test;
  localparam int A_CA = 0, A_CB = 1, A_ST = 2, A_CH = 3, A_CL = 4;
  localparam int A_1H = 5, A_1L = 6, A_2H = 7, A_2L = 8;

  logic       clk, arst_n, bus_sel, bus_wr, bus_rd, irq_mask, irq;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [1:0] ocmp_out, ocmp_oe;
  int total = 0, bad = 0;

  ocmp_timer uut (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mask(irq_mask), .irq(irq), .ocmp_out(ocmp_out), .ocmp_oe(ocmp_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input int a, output int d);
    @(negedge clk); bus_addr = 4'(a); #1; d = int'(bus_rdata);
  endtask

  task automatic bwrite(input int a, input int d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input int a, output int d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 4'(a); #1; d = int'(bus_rdata);
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic read_cnt(output int c);
    int h, l, h2;
    do begin peek(A_CH, h); peek(A_CL, l); peek(A_CH, h2); end while (h != h2);
    c = (h << 8) | l;
  endtask

  task automatic set_cmp(input int ch, input int v);
    bwrite(ch == 1 ? A_1H : A_2H, (v >> 8) & 8'hFF);
    bwrite(ch == 1 ? A_1L : A_2L, v & 8'hFF);
  endtask

  task automatic wait_flag(input int bitn, input int limit, output bit seen);
    int s;
    seen = 0;
    for (int k = 0; k < limit && !seen; k++) begin
      peek(A_ST, s);
      if (s[bitn]) seen = 1;
    end
  endtask

  task automatic clr_flag(input int ch);
    int d;
    bread(A_ST, d); bread(ch == 1 ? A_1L : A_2L, d);
  endtask

  task automatic t_reset;
    int d;
    arst_n = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; irq_mask = 0;
    repeat (3) @(negedge clk);
    peek(A_CH, d); check("R1 cnt hi", d, 0);
    peek(A_CL, d); check("R1 cnt lo", d, 0);
    peek(A_1H, d); check("R1/R4 cmp1 hi", d, 8'h80);
    peek(A_1L, d); check("R1/R4 cmp1 lo", d, 0);
    peek(A_2H, d); check("R1/R4 cmp2 hi", d, 8'h80);
    peek(A_2L, d); check("R1/R4 cmp2 lo", d, 0);
    peek(A_ST, d); check("R1 status", d, 0);
    peek(A_CA, d); check("R1 ctrl a", d, 0);
    peek(A_CB, d); check("R1 ctrl b", d, 0);
    check("R1 irq", int'(irq), 0);
    check("R1 pins", int'(ocmp_out), 0);
    check("R1 oe", int'(ocmp_oe), 0);
    @(negedge clk); arst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input int sel, input int exp);
    int prev, cur, n;
    bwrite(A_CB, sel);
    peek(A_CL, prev); cur = prev;
    for (int k = 0; k < 20 && cur == prev; k++) peek(A_CL, cur);
    prev = cur; n = 0;
    for (int k = 0; k < 20 && cur == prev; k++) begin peek(A_CL, cur); n++; end
    check($sformatf("R2 period sel=%0d", sel), n, exp);
    check("R3 step by one", cur, (prev + 1) & 8'hFF);
  endtask

  task automatic t_prescale;
    measure(0, 2); measure(1, 4); measure(2, 8); measure(3, 8);
  endtask

  task automatic t_match;
    int c, t, d; bit seen;
    bwrite(A_CA, 8'h02);          // lvl1=1, irq off
    bwrite(A_CB, 8'h06);          // /8, oe1
    read_cnt(c); t = c + 20;
    set_cmp(1, t);
    check("R7 pin before match", int'(ocmp_out), 0);
    wait_flag(0, 2000, seen);
    check("R6 flag1 seen", int'(seen), 1);
    peek(A_CL, d); check("R6 cnt after match", d, (t + 1) & 8'hFF);
    check("R7 pin1 takes level", int'(ocmp_out[0]), 1);
    check("R7 oe1 shown", int'(ocmp_oe), 1);
    peek(A_ST, d); check("R12 flag2 untouched", d, 1);
    check("R9 irq off when disabled", int'(irq), 0);
    peek(A_1H, d); check("R5 cmp1 hi kept", d, (t >> 8) & 8'hFF);
    peek(A_1L, d); check("R5 cmp1 lo kept", d, t & 8'hFF);
  endtask

  task automatic t_irq;
    bwrite(A_CA, 8'h03);
    @(negedge clk); check("R9 irq raised", int'(irq), 1);
    irq_mask = 1; #1; check("R9 irq masked", int'(irq), 0);
    irq_mask = 0; #1; check("R9 irq unmasked", int'(irq), 1);
    bwrite(A_CA, 8'h02);
    @(negedge clk); check("R9 irq disabled", int'(irq), 0);
  endtask

  task automatic t_flag_clear;
    int d;
    bread(A_1L, d);
    peek(A_ST, d); check("R11 low access alone keeps flag", d & 1, 1);
    bread(A_ST, d);
    peek(A_ST, d); check("R11 status read alone keeps flag", d & 1, 1);
    bread(A_1L, d);
    peek(A_ST, d); check("R11 flag cleared by sequence", d & 1, 0);
  endtask

  task automatic t_oe;
    int c; bit seen;
    bwrite(A_CA, 8'h00);          // lvl1=0
    bwrite(A_CB, 8'h02);          // /8, oe off
    read_cnt(c); set_cmp(1, c + 20);
    wait_flag(0, 2000, seen);
    check("R6 flag1 with oe off", int'(seen), 1);
    check("R8 pin1 kept with oe off", int'(ocmp_out[0]), 1);
    check("R7 oe1 low", int'(ocmp_oe), 0);
    bwrite(A_CB, 8'h06);
    clr_flag(1);
    read_cnt(c); set_cmp(1, c + 20);
    wait_flag(0, 2000, seen);
    check("R7 pin1 takes low level", int'(ocmp_out[0]), 0);
  endtask

  task automatic t_hold;
    int c, d, v; bit seen;
    clr_flag(1);
    read_cnt(c); v = c + 24;
    bwrite(A_1L, v & 8'hFF);
    bwrite(A_1H, (v >> 8) & 8'hFF);   // full value loaded, low write pending
    repeat (400) @(negedge clk);
    peek(A_ST, d); check("R10 no event while held", d & 1, 0);
    peek(A_1H, d); check("R5 held cmp hi", d, (v >> 8) & 8'hFF);
    peek(A_1L, d); check("R5 held cmp lo", d, v & 8'hFF);
    read_cnt(c); set_cmp(1, c + 24);
    wait_flag(0, 2000, seen);
    check("R10 events resume after low write", int'(seen), 1);
  endtask

  task automatic t_ch2;
    int c, d; bit seen;
    clr_flag(1);
    bwrite(A_CA, 8'h04);          // lvl2=1
    bwrite(A_CB, 8'h0A);          // /8, oe2
    read_cnt(c); set_cmp(2, c + 24);
    wait_flag(1, 2000, seen);
    check("R6 flag2 seen", int'(seen), 1);
    peek(A_ST, d); check("R12 only flag2", d, 2);
    check("R12 pins", int'(ocmp_out), 2);
    check("R7 oe2 shown", int'(ocmp_oe), 2);
  endtask

  task automatic t_wrap;
    int d; bit seen;
    clr_flag(2);
    set_cmp(2, 0);
    bwrite(A_CB, 8'h08);          // /2, oe2
    wait_flag(1, 140000, seen);
    check("R3 wrap reaches zero", int'(seen), 1);
    peek(A_CL, d); check("R3 cnt lo after wrap", d, 1);
    peek(A_CH, d); check("R3 cnt hi after wrap", d, 0);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_match();
    t_irq();
    t_flag_clear();
    t_oe();
    t_hold();
    t_ch2();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule